// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable slave that answers a master on a select / clock / data-in / data-out serial link the way a small serial EEPROM does. The serial clock, select and data-in pins are brought into the system clock domain through a two-flop synchronizer. The block detects rising serial-clock edges and decodes framed commands: a start bit, a two-bit opcode, an address and an optional data field. It can read a word, write a word, erase a word, write the whole array, erase the whole array, and set or clear a write-enable latch.

A register array of 1024 bits (by default) stands in for the non-volatile cells. A static organisation pin selects how that array is presented: as 64 words of 16 bits or as 128 bytes of 8 bits. Programming commands take effect on the falling edge of select. They run for a fixed number of system clocks. While they run, the block reports busy or ready on the data-out line whenever select is raised. The pad is represented as an output value plus an output-enable.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset, and whenever select is low, `so_oe` is 0. With select high and no read or status pending, `so_oe` also stays 0.
- R2: Zeros clocked in while idle are ignored. A frame begins at the first 1 sampled on a rising serial-clock edge with select high. The frame is then a 2-bit opcode followed by the address, MSB first.
- R3: Opcode 10 is a read. On the edge that takes in the last address bit, the output is enabled and drives a single 0. Each following rising edge presents the next bit of the addressed word, MSB first.
- R4: With `org_wide`=1 the address is 6 bits and data is 16 bits. With `org_wide`=0 the address is 7 bits and data is 8 bits. Address bit 0 then picks the byte lane (0 = low byte, 1 = high byte) of the word given by address bits 6..1.
- R5: Opcode 01 is a word write with a data field. It programs only if the write-enable latch is set when select falls; otherwise it has no effect and no busy status appears. The latch is clear after reset.
- R6: Opcode 00 is decoded by the two top address bits: 11 sets the write-enable latch, 00 clears it, 01 is write-all (with data), 10 is erase-all. The remaining address bits are ignored. Latch changes take effect when select falls.
- R7: Opcode 11 erases one location to all ones. Erase-all sets every word to all ones, and write-all stores the data field in every location.
- R8: While programming runs, raising select drives the output enabled at 0 (busy). After PROG_CYCLES system clocks it drives 1 (ready), with no serial clock needed.
- R9: A start bit clocked in while ready is shown turns the output enable off, and that bit begins the next command.
- R10: A rising serial-clock edge after the last bit of a complete frame, before select falls, aborts the frame, so nothing is programmed.
- R11: Serial activity while programming is busy is ignored and cannot start a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Select, active high |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data in |
| org_wide | input | 1 | Organisation: 1 = 16-bit words, 0 = 8-bit bytes |
| so_val | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data pad |

## Verification
Reads are issued with and without leading zeros before the start bit, so that a decoder which requires the start bit first is told apart from a correct one. Written values with distinct high and low bytes (1234, BEEF, 5A into one lane and A5 into the other) expose bit-order mistakes, dummy-bit shifts and swapped byte lanes. The same word is read back in both organisations. Programming is tried in four ways: with the latch set, with the latch cleared, after an aborting extra clock, and with a second frame sent during busy. Each is followed by a readback, which separates gating faults from data-path faults. Erase-all and write-all are checked at the first and last words to catch a sweep that stops short.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_WEN, K_WDS, K_WRITE, K_WRAL, K_ERASE, K_ERAL
  } kind_t;

  typedef enum logic [2:0] {
    F_IDLE, F_OPC, F_ADDR, F_DATA, F_RD, F_DONE, F_ABORT
  } fstate_t;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          sk_rise,
  input  logic          di_s,
  input  logic          org,
  input  logic          busy,
  input  logic [DW/2-1:0] rd_hi,
  input  logic [DW/2-1:0] rd_lo,
  output logic          cmd_valid,
  output kind_t         cmd_kind,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          start_seen,
  output logic          rd_active,
  output logic          rd_bit
);
  localparam int BW = DW / 2;
  localparam int CW = $clog2(DW) + 1;

  fstate_t       state;
  kind_t         kind, kind_n;
  logic [1:0]    opc;
  logic [CW-1:0] cnt, alen, dlen;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, shreg, sel_word;
  logic [1:0]    top2;
  logic          loaded;

  assign alen = org ? CW'(AW - 1) : CW'(AW);
  assign dlen = org ? CW'(DW) : CW'(BW);
  assign sel_word = org ? {rd_hi, rd_lo}
                        : {(addr_q[0] ? rd_hi : rd_lo), {BW{1'b0}}};

  always_comb begin
    addr_n = {addr_q[AW-2:0], di_s};
    top2   = org ? addr_n[AW-2:AW-3] : addr_n[AW-1:AW-2];
    case (opc)
      2'b01:   kind_n = K_WRITE;
      2'b11:   kind_n = K_ERASE;
      2'b10:   kind_n = K_NONE;
      default: case (top2)
        2'b11:   kind_n = K_WEN;
        2'b00:   kind_n = K_WDS;
        2'b01:   kind_n = K_WRAL;
        default: kind_n = K_ERAL;
      endcase
    endcase
  end

  always_ff @(posedge clk) begin
    cmd_valid  <= 1'b0;
    start_seen <= 1'b0;
    if (rst) begin
      state <= F_IDLE; kind <= K_NONE; opc <= '0; cnt <= '0;
      addr_q <= '0; data_q <= '0; shreg <= '0; loaded <= 1'b0;
      rd_active <= 1'b0; rd_bit <= 1'b0;
    end else if (!cs_s) begin
      if (state == F_DONE && kind != K_NONE) cmd_valid <= 1'b1;
      state     <= F_IDLE;
      rd_active <= 1'b0;
    end else if (sk_rise) begin
      case (state)
        F_IDLE: if (di_s && !busy) begin
          state <= F_OPC; cnt <= '0; start_seen <= 1'b1;
          addr_q <= '0; data_q <= '0; kind <= K_NONE;
        end
        F_OPC: begin
          opc <= {opc[0], di_s};
          if (cnt == CW'(1)) begin state <= F_ADDR; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        F_ADDR: begin
          addr_q <= addr_n;
          if (cnt == alen - 1'b1) begin
            cnt <= '0;
            kind <= kind_n;
            if (opc == 2'b10) begin
              state <= F_RD; rd_active <= 1'b1; rd_bit <= 1'b0; loaded <= 1'b0;
            end else if (kind_n == K_WRITE || kind_n == K_WRAL) state <= F_DATA;
            else state <= F_DONE;
          end else cnt <= cnt + 1'b1;
        end
        F_DATA: begin
          data_q <= {data_q[DW-2:0], di_s};
          if (cnt == dlen - 1'b1) state <= F_DONE;
          else cnt <= cnt + 1'b1;
        end
        F_RD: begin
          if (!loaded) begin
            loaded <= 1'b1;
            rd_bit <= sel_word[DW-1];
            shreg  <= {sel_word[DW-2:0], 1'b0};
          end else begin
            rd_bit <= shreg[DW-1];
            shreg  <= {shreg[DW-2:0], 1'b0};
          end
        end
        F_DONE:  state <= F_ABORT;
        default: state <= state;
      endcase
    end
  end

  assign cmd_kind = kind;
  assign cmd_addr = addr_q;
  assign cmd_data = data_q;

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    (state == F_IDLE && busy) |=> state == F_IDLE);
  // R2
  start_chk: assert property (@(posedge clk) disable iff (rst)
    start_seen |-> state == F_OPC);
endmodule

// File: rtl/mw_store.sv
module mw_store
  import mw_pkg::*;
#(
  parameter int DW          = 16,
  parameter int NWORDS      = 64,
  parameter int PROG_CYCLES = 100
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    org,
  input  logic                    cmd_valid,
  input  kind_t                   cmd_kind,
  input  logic [$clog2(NWORDS):0] cmd_addr,
  input  logic [DW-1:0]           cmd_data,
  input  logic [$clog2(NWORDS):0] rd_addr,
  input  logic                    start_seen,
  output logic                    busy,
  output logic                    status,
  output logic [DW/2-1:0]         rd_hi,
  output logic [DW/2-1:0]         rd_lo
);
  localparam int BW   = DW / 2;
  localparam int WA   = $clog2(NWORDS);
  localparam int AW   = WA + 1;
  localparam int TLEN = (PROG_CYCLES > NWORDS) ? PROG_CYCLES : NWORDS;
  localparam int TW   = $clog2(TLEN + 1);

  logic [BW-1:0] mem_hi [NWORDS];
  logic [BW-1:0] mem_lo [NWORDS];

  logic          wen, bulk, en_hi, en_lo, we_hi, we_lo, prog_req, erase;
  logic [TW-1:0] tcnt;
  logic [WA-1:0] waddr_q, wa, ra;
  logic [BW-1:0] d_hi, d_lo, byte_src;

  function automatic logic [WA-1:0] widx(input logic [AW-1:0] a, input logic o);
    return o ? a[WA-1:0] : a[WA:1];
  endfunction

  assign prog_req = cmd_valid && (cmd_kind == K_WRITE || cmd_kind == K_WRAL ||
                                  cmd_kind == K_ERASE || cmd_kind == K_ERAL);
  assign erase    = (cmd_kind == K_ERASE || cmd_kind == K_ERAL);
  assign byte_src = erase ? {BW{1'b1}} : cmd_data[BW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wen <= 1'b0; busy <= 1'b0; status <= 1'b0; tcnt <= '0; bulk <= 1'b0;
      en_hi <= 1'b0; en_lo <= 1'b0; waddr_q <= '0; d_hi <= '0; d_lo <= '0;
    end else begin
      if (start_seen) status <= 1'b0;
      if (cmd_valid && cmd_kind == K_WEN) wen <= 1'b1;
      if (cmd_valid && cmd_kind == K_WDS) wen <= 1'b0;
      if (prog_req && wen && !busy) begin
        busy    <= 1'b1;
        status  <= 1'b1;
        tcnt    <= '0;
        bulk    <= (cmd_kind == K_WRAL || cmd_kind == K_ERAL);
        waddr_q <= widx(cmd_addr, org);
        if (org) begin
          d_hi  <= erase ? {BW{1'b1}} : cmd_data[DW-1:BW];
          d_lo  <= byte_src;
          en_hi <= 1'b1;
          en_lo <= 1'b1;
        end else begin
          d_hi  <= byte_src;
          d_lo  <= byte_src;
          en_hi <= (cmd_kind == K_WRAL || cmd_kind == K_ERAL) || cmd_addr[0];
          en_lo <= (cmd_kind == K_WRAL || cmd_kind == K_ERAL) || !cmd_addr[0];
        end
      end else if (busy) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == TW'(TLEN - 1)) busy <= 1'b0;
      end
    end
  end

  assign we_hi = busy && en_hi && (bulk ? (tcnt < TW'(NWORDS)) : (tcnt == '0));
  assign we_lo = busy && en_lo && (bulk ? (tcnt < TW'(NWORDS)) : (tcnt == '0));
  assign wa    = bulk ? tcnt[WA-1:0] : waddr_q;
  assign ra    = widx(rd_addr, org);

  always_ff @(posedge clk) begin
    if (we_hi) mem_hi[wa] <= d_hi;
    rd_hi <= mem_hi[ra];
  end

  always_ff @(posedge clk) begin
    if (we_lo) mem_lo[wa] <= d_lo;
    rd_lo <= mem_lo[ra];
  end

  // R5
  prog_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wen) && $past(cmd_valid));
  // R6
  wen_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wen) |-> $past(cmd_valid) && $past(cmd_kind) == K_WEN);
  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> status);
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int DW          = 16,
  parameter int NWORDS      = 64,
  parameter int PROG_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  input  logic org_wide,
  output logic so_val,
  output logic so_oe
);
  localparam int AW = $clog2(NWORDS) + 1;
  localparam int BW = DW / 2;

  logic [2:0]    sync_q;
  logic          cs_s, sk_s, di_s, sk_d, sk_rise;
  logic          cmd_valid, start_seen, rd_active, rd_bit, busy, status;
  kind_t         cmd_kind;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic [BW-1:0] rd_hi, rd_lo;

  mw_sync #(.W(3)) u_sync (
    .clk(clk), .rst(rst), .d({sel, sclk, sdi}), .q(sync_q)
  );
  assign {cs_s, sk_s, di_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) sk_d <= 1'b0;
    else     sk_d <= sk_s;
  end
  assign sk_rise = sk_s && !sk_d;

  mw_frame #(.DW(DW), .AW(AW)) u_frame (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s),
    .org(org_wide), .busy(busy), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .start_seen(start_seen), .rd_active(rd_active),
    .rd_bit(rd_bit)
  );

  mw_store #(.DW(DW), .NWORDS(NWORDS), .PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk(clk), .rst(rst), .org(org_wide), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_addr(cmd_addr), .start_seen(start_seen), .busy(busy),
    .status(status), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      so_oe  <= 1'b0;
      so_val <= 1'b0;
    end else begin
      so_oe  <= cs_s && (rd_active || status);
      so_val <= rd_active ? rd_bit : (status && !busy);
    end
  end

  // R1
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !so_oe);
endmodule

// File: tb/mw_eeprom_slave_test.sv
module mw_eeprom_slave_test;
  localparam int PROG = 2000;

  logic clk = 1'b0, rst = 1'b1, sel = 1'b0, sclk = 1'b0, sdi = 1'b0, org_wide = 1'b1;
  logic so_val, so_oe;

  always #5 clk = ~clk;

  mw_eeprom_slave #(.DW(16), .NWORDS(64), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst(rst), .sel(sel), .sclk(sclk), .sdi(sdi),
    .org_wide(org_wide), .so_val(so_val), .so_oe(so_oe)
  );

  typedef struct { logic [15:0] val; string tag; } item_t;
  item_t       exp_q[$];
  logic [15:0] act_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops read results and compares with the scoreboard
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0) begin
      logic [15:0] a;
      a = act_q.pop_front();
      if (exp_q.size() == 0) chk("R3 unexpected read", a, 16'hxxxx);
      else begin
        item_t e;
        e = exp_q.pop_front();
        chk(e.tag, a, e.val);
      end
    end
  end

  function automatic int aw(); return org_wide ? 6 : 7; endfunction
  function automatic int dw(); return org_wide ? 16 : 8; endfunction

  task automatic sk_bit(input logic b);
    @(negedge clk) sdi = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (8) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask

  task automatic cs_up();
    @(negedge clk) sel = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk) sel = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] addr,
                       input logic [31:0] data, input bit with_data);
    cs_up();
    sk_bit(1'b1);
    send({30'd0, op}, 2);
    send(addr, aw());
    if (with_data) send(data, dw());
  endtask

  task automatic special(input logic [1:0] code);
    issue(2'b00, 32'(code) << (aw() - 2), 0, 0);
    cs_down();
  endtask

  task automatic wait_prog();
    cs_down();
    repeat (PROG + 50) @(negedge clk);
  endtask

  // driver: pushes expected item, then runs the read frame
  task automatic read_word(input logic [31:0] addr, input logic [15:0] exp,
                           input string tag, input int zeros, input bit clear);
    logic [15:0] w;
    exp_q.push_back('{exp, tag});
    if (!clear) cs_up();
    for (int i = 0; i < zeros; i++) sk_bit(1'b0);
    sk_bit(1'b1);
    if (clear) chk("R9 start bit clears ready", {15'd0, so_oe}, 16'd0);
    send(32'd2, 2);
    send(addr, aw());
    chk("R3 dummy bit", {14'd0, so_oe, so_val}, 16'd2);
    w = '0;
    for (int i = 0; i < dw(); i++) begin
      sk_bit(1'b0);
      w = {w[14:0], so_val};
    end
    act_q.push_back(w);
    cs_down();
  endtask

  task automatic status_chk(input string tag, input logic [1:0] exp);
    cs_up();
    chk(tag, {14'd0, so_oe, so_val}, {14'd0, exp});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 oe after reset", {15'd0, so_oe}, 16'd0);
    cs_up();
    chk("R1 oe with select idle", {15'd0, so_oe}, 16'd0);
    cs_down();

    // write while disabled after reset
    issue(2'b01, 5, 16'hA5A5, 1);
    cs_down();
    status_chk("R5 no busy when disabled", 2'b00);
    cs_down();

    special(2'b11);                 // enable
    special(2'b10);                 // erase-all
    status_chk("R8 busy during erase-all", 2'b10);
    cs_down();
    repeat (PROG + 50) @(negedge clk);
    status_chk("R8 ready after programming", 2'b11);
    read_word(5, 16'hFFFF, "R7 erase-all word 5", 0, 1);

    issue(2'b01, 5, 16'h1234, 1); wait_prog();
    issue(2'b01, 6, 16'hBEEF, 1); wait_prog();
    read_word(5, 16'h1234, "R2 leading zeros read 5", 3, 0);
    read_word(6, 16'hBEEF, "R3 read 6", 0, 0);
    read_word(63, 16'hFFFF, "R7 erase-all last word", 0, 0);

    issue(2'b11, 6, 0, 0); wait_prog();
    read_word(6, 16'hFFFF, "R7 erase word 6", 0, 0);

    issue(2'b01, 7, 16'h0F0F, 1);
    sk_bit(1'b0);                   // extra edge aborts
    cs_down();
    status_chk("R10 abort leaves no busy", 2'b00);
    cs_down();
    read_word(7, 16'hFFFF, "R10 aborted write", 0, 0);

    issue(2'b01, 8, 16'h5555, 1);
    cs_down();
    cs_up();
    send({1'b1, 2'b01, 6'd9, 16'h7777}, 25);
    cs_down();
    repeat (PROG + 50) @(negedge clk);
    read_word(9, 16'hFFFF, "R11 frame ignored while busy", 0, 0);
    read_word(8, 16'h5555, "R11 first write kept", 0, 0);

    special(2'b00);                 // disable
    issue(2'b01, 5, 16'h0000, 1);
    cs_down();
    status_chk("R6 disable blocks write", 2'b00);
    cs_down();
    read_word(5, 16'h1234, "R6 word unchanged after disable", 0, 0);

    special(2'b11);
    issue(2'b00, 32'h10, 16'hC3C3, 1); wait_prog();
    read_word(0, 16'hC3C3, "R7 write-all word 0", 0, 0);
    read_word(63, 16'hC3C3, "R7 write-all word 63", 0, 0);

    org_wide = 1'b0;
    repeat (4) @(negedge clk);
    issue(2'b01, 10, 16'h005A, 1); wait_prog();
    issue(2'b01, 11, 16'h00A5, 1); wait_prog();
    read_word(10, 16'h005A, "R4 byte 10", 0, 0);
    read_word(11, 16'h00A5, "R4 byte 11", 0, 0);
    read_word(12, 16'h00C3, "R4 neighbour byte 12", 0, 0);
    org_wide = 1'b1;
    repeat (4) @(negedge clk);
    read_word(5, 16'hA55A, "R4 lane mapping word 5", 0, 0);

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) chk("R3 missing read results", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule